// File: doc/BRIEF.md
# Packed Integer-to-Float Conversion Unit

This unit turns a vector of signed 32-bit two's-complement integers into IEEE-754 single-precision values, lane by lane, with each result in the same bit position as its source integer. A 256-bit source carries up to eight lanes. A mode input picks how many lanes are active and what happens to the upper 128 bits of the result. In the compatibility 128-bit mode the upper half keeps the prior destination value. In the extended 128-bit mode the upper half is cleared. In the extended 256-bit mode all eight lanes are converted.

In the extended modes a 4-bit operand-specifier field must be all ones. If it is not, the unit raises an undefined-opcode fault and returns the prior destination unchanged. A rounding-mode input controls how a lane is rounded when its integer needs more than 24 significant bits. An inexact flag reports whether any active lane was rounded. A valid strobe travels with the data, with a fixed latency that a parameter selects.

Top module: `pack_i2f_unit`

## Requirements
- R1: Each active lane converts its signed integer to the single-precision encoding of the same value. Zero gives 0x00000000, and 0x80000000 gives 0xCF000000. A lane whose magnitude fits in 24 bits converts exactly.
- R2: Mode encoding is 00 compatibility 128-bit, 01 extended 128-bit, 10 extended 256-bit and 11 reserved. The 128-bit modes convert lanes 0..3 (bits 127:0). The 256-bit mode converts lanes 0..7 (bits 255:0).
- R3: In mode 00, result bits 255:128 equal the prior destination bits 255:128.
- R4: In mode 01, result bits 255:128 are zero.
- R5: In modes 01 and 10, a specifier field other than 4'b1111 raises ud_fault. Mode 11 also raises ud_fault. On a fault the whole result equals the prior destination and inexact is 0. In mode 00 the specifier field is ignored.
- R6: Rounding encoding is 00 to nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R7: inexact is the OR of the per-lane rounding conditions over the active lanes only. Upper-half source lanes in the 128-bit modes never set it.
- R8: With OUT_REG=1, out_valid rises one clock after in_valid and the outputs change only then. After reset, out_valid, result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| src_vec | input | 256 | Packed signed integer lanes |
| dst_prior | input | 256 | Prior destination value |
| vec_mode | input | 2 | Lane/merge mode (R2 encoding) |
| spec_field | input | 4 | Reserved operand-specifier field |
| rnd_mode | input | 2 | Rounding mode (R6 encoding) |
| out_valid | output | 1 | Result strobe |
| result | output | 256 | Packed single-precision result |
| inexact | output | 1 | Precision flag |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
Rounding and upper-lane merging act in the same cycle. The bench provokes this with 128-bit transfers whose upper source lanes hold wide integers that would round. Lower lanes hold values near the 24-bit boundary, including ties. The bench then judges that the upper result half follows R3 or R4 and that inexact reflects only the lower lanes. The fault check and rounding also meet. Extended-mode transfers with a bad specifier field carry inexact-prone lanes, and the bench expects the prior destination and a clear inexact flag.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int unsigned FW = 32;

  typedef enum logic [1:0] {
    VM_LEG128 = 2'b00,
    VM_EXT128 = 2'b01,
    VM_EXT256 = 2'b10,
    VM_RSVD   = 2'b11
  } vmode_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;
endpackage

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vin,
  output logic [CW-1:0] zcnt
);
  // highest set bit wins because it is visited last
  always_comb begin
    zcnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vin[i]) zcnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/i2f_lane.sv
module i2f_lane
  import i2f_pkg::*;
(
  input  logic [FW-1:0] ival,
  input  rnd_e          rnd,
  output logic [FW-1:0] fval,
  output logic          inexact
);
  localparam int CW   = $clog2(FW) + 1;
  localparam int MANT = 23;
  localparam int DROP = FW - 1 - MANT;          // bits below the kept mantissa
  localparam logic [7:0] EXP_TOP = 8'(127 + FW - 1);

  logic          sgn;
  logic [FW-1:0] mag;
  logic [CW-1:0] lz;
  logic [FW-1:0] norm;
  logic          guard, sticky, lsb, bump;
  logic [7:0]    bexp;
  logic [30:0]   body, rounded;

  assign sgn = ival[FW-1];
  assign mag = sgn ? (~ival + 1'b1) : ival;

  i2f_lzc #(.W(FW), .CW(CW)) u_lzc (.vin(mag), .zcnt(lz));

  assign norm   = mag << lz[CW-2:0];
  assign lsb    = norm[DROP];
  assign guard  = norm[DROP-1];
  assign sticky = |norm[DROP-2:0];
  assign inexact = guard | sticky;

  always_comb begin
    unique case (rnd)
      RND_NEAR: bump = guard & (sticky | lsb);
      RND_DOWN: bump = inexact & sgn;
      RND_UP:   bump = inexact & ~sgn;
      default:  bump = 1'b0;
    endcase
  end

  assign bexp    = EXP_TOP - {{(8-CW){1'b0}}, lz};
  assign body    = {bexp, norm[FW-2:DROP]};
  assign rounded = body + {30'd0, bump};       // carry may ripple into exponent
  assign fval    = (mag == '0) ? '0 : {sgn, rounded};

  // R1: magnitudes of at most 24 significant bits never round
  always_comb begin
    if (lz >= CW'(DROP)) begin
      a_r1_short_exact: assert (!inexact);
    end
  end
endmodule

// File: rtl/i2f_merge.sv
module i2f_merge
  import i2f_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LW    = 32
) (
  input  logic [LANES*LW-1:0] conv,
  input  logic [LANES*LW-1:0] prior,
  input  vmode_e              mode,
  input  logic                fault,
  output logic [LANES*LW-1:0] merged
);
  localparam int HALF = LANES / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_ln
    if (i < HALF) begin : g_lo
      assign merged[i*LW +: LW] = fault ? prior[i*LW +: LW] : conv[i*LW +: LW];
    end else begin : g_hi
      always_comb begin
        if (fault || mode == VM_LEG128) merged[i*LW +: LW] = prior[i*LW +: LW];
        else if (mode == VM_EXT128)     merged[i*LW +: LW] = '0;
        else                            merged[i*LW +: LW] = conv[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/pack_i2f_unit.sv
module pack_i2f_unit
  import i2f_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int OUT_REG = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [LANES*FW-1:0]  src_vec,
  input  logic [LANES*FW-1:0]  dst_prior,
  input  logic [1:0]           vec_mode,
  input  logic [3:0]           spec_field,
  input  logic [1:0]           rnd_mode,
  output logic                 out_valid,
  output logic [LANES*FW-1:0]  result,
  output logic                 inexact,
  output logic                 ud_fault
);
  localparam int VW   = LANES * FW;
  localparam int HALF = LANES / 2;

  vmode_e            mode;
  rnd_e              rnd;
  logic [VW-1:0]     conv, merged;
  logic [LANES-1:0]  lane_inex, lane_act;
  logic              fault_c, inex_c;

  assign mode = vmode_e'(vec_mode);
  assign rnd  = rnd_e'(rnd_mode);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    i2f_lane u_lane (
      .ival   (src_vec[i*FW +: FW]),
      .rnd    (rnd),
      .fval   (conv[i*FW +: FW]),
      .inexact(lane_inex[i])
    );
    assign lane_act[i] = (i < HALF) || (mode == VM_EXT256);
  end

  assign fault_c = (mode == VM_RSVD) || ((mode != VM_LEG128) && (spec_field != 4'hF));
  assign inex_c  = !fault_c && |(lane_inex & lane_act);

  i2f_merge #(.LANES(LANES), .LW(FW)) u_merge (
    .conv  (conv),
    .prior (dst_prior),
    .mode  (mode),
    .fault (fault_c),
    .merged(merged)
  );

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        result    <= '0;
        inexact   <= 1'b0;
        ud_fault  <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result   <= merged;
          inexact  <= inex_c;
          ud_fault <= fault_c;
        end
      end
    end

    // R8: strobe latency of one clock
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R5: a fault hands back the prior destination untouched
    a_r5_fault_keeps_dest: assert property (@(posedge clk) disable iff (rst)
      (out_valid && ud_fault) |-> (result == $past(dst_prior)));
    // R5: a fault never reports precision loss
    a_r5_fault_no_inexact: assert property (@(posedge clk) disable iff (rst)
      (out_valid && ud_fault) |-> !inexact);
    // R4: extended 128-bit mode clears the upper half
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !ud_fault && $past(vec_mode) == 2'b01) |-> (result[VW-1:VW/2] == '0));
    // R3: compatibility mode passes the upper half through
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(vec_mode) == 2'b00) |-> (result[VW-1:VW/2] == $past(dst_prior[VW-1:VW/2])));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = merged;
    assign inexact   = inex_c;
    assign ud_fault  = fault_c;
  end
endmodule

// File: tb/pack_i2f_unit_test.sv
module pack_i2f_unit_test;
  localparam int LANES = 8;
  localparam int VW    = LANES * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [VW-1:0] src_vec = '0, dst_prior = '0;
  logic [1:0]    vec_mode = 2'b00, rnd_mode = 2'b00;
  logic [3:0]    spec_field = 4'hF;
  logic          out_valid, inexact, ud_fault;
  logic [VW-1:0] result;

  always #10 clk = ~clk;  // 50 MHz

  pack_i2f_unit #(.LANES(LANES), .OUT_REG(1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .dst_prior(dst_prior), .vec_mode(vec_mode), .spec_field(spec_field),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .result(result),
    .inexact(inexact), .ud_fault(ud_fault)
  );

  typedef struct {
    logic [VW-1:0] res;
    logic          inx;
    logic          flt;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done  = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  // independent model: find msb, shift, compare remainder with half
  function automatic logic [32:0] model(logic [31:0] x, logic [1:0] rm);
    logic        s = x[31];
    logic [31:0] m = s ? (32'd0 - x) : x;
    logic [31:0] q, rem, half;
    logic        ix = 1'b0, up = 1'b0;
    int          p = 0, sh;
    if (m == 0) return 33'd0;
    for (int i = 0; i < 32; i++) if (m[i]) p = i;
    if (p <= 23) q = m << (23 - p);
    else begin
      sh   = p - 23;
      q    = m >> sh;
      rem  = m & ((32'd1 << sh) - 1);
      half = 32'd1 << (sh - 1);
      ix   = (rem != 0);
      case (rm)
        2'b00: up = (rem > half) || (rem == half && q[0]);
        2'b01: up = ix && s;
        2'b10: up = ix && !s;
        default: up = 1'b0;
      endcase
      q = q + {31'd0, up};
      if (q[24]) begin q = q >> 1; p = p + 1; end
    end
    return {ix, s, 8'(127 + p), q[22:0]};
  endfunction

  function automatic logic [31:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(logic [VW-1:0] s, logic [VW-1:0] d, logic [1:0] md,
                      logic [3:0] sp, logic [1:0] rm, string tag);
    exp_t e;
    logic [32:0] r;
    int act_n;
    e.flt = (md == 2'b11) || (md != 2'b00 && sp != 4'hF);
    e.inx = 1'b0;
    e.res = d;
    e.tag = tag;
    act_n = (md == 2'b10) ? 8 : 4;
    if (!e.flt) begin
      for (int i = 0; i < LANES; i++) begin
        r = model(s[i*32 +: 32], rm);
        if (i < act_n) begin
          e.res[i*32 +: 32] = r[31:0];
          e.inx = e.inx | r[32];
        end else if (md == 2'b01) e.res[i*32 +: 32] = 32'd0;
      end
    end
    @(negedge clk);
    src_vec = s; dst_prior = d; vec_mode = md; spec_field = sp; rnd_mode = rm;
    in_valid = 1'b1;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_vec = {8{nxt()}};
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8 unexpected out_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " result"}, result, e.res);
        check({e.tag, " R7 inexact"}, {255'd0, inexact}, {255'd0, e.inx});
        check({e.tag, " R5 fault"}, {255'd0, ud_fault}, {255'd0, e.flt});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  logic [VW-1:0] d0, s0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8 reset valid", {255'd0, out_valid}, '0);
    check("R8 reset result", result, '0);
    check("R8 reset flags", {254'd0, inexact, ud_fault}, '0);

    d0 = {8{32'hDEAD_BEEF}};
    // R1 special values: zero, most negative, small exact, negative one
    s0 = {32'd5, 32'hFFFF_FFFF, 32'd1, 32'd16777215, 32'h8000_0000, 32'd0, 32'hFF00_0000, 32'd7};
    send(s0, d0, 2'b10, 4'hF, 2'b00, "R1 R2 exact");
    // R6 ties and the top of range in every rounding mode
    for (int rm = 0; rm < 4; rm++) begin
      s0 = {32'd16777217, 32'd16777219, 32'h7FFF_FFFF, 32'h8000_0001,
            32'hFEFF_FFFF, 32'd33554435, 32'hFFFF_FFFF - 32'd16777218, 32'd100};
      send(s0, d0, 2'b10, 4'hF, 2'(rm), "R6 rounding");
    end
    // R3 and R7: wide upper source lanes ignored in compatibility mode
    s0 = {{4{32'h7FFF_FFFF}}, 32'd1, 32'd2, 32'd3, 32'hFFFF_FFFC};
    send(s0, d0, 2'b00, 4'hF, 2'b00, "R3 R7 legacy upper kept");
    // R5 ignored specifier in compatibility mode
    send(s0, d0, 2'b00, 4'h0, 2'b10, "R5 R3 legacy spec ignored");
    // R4 and R7 in extended 128-bit mode
    send(s0, d0, 2'b01, 4'hF, 2'b00, "R4 R7 ext128 upper zero");
    s0 = {{4{32'd1}}, 32'h7FFF_FFFF, 32'd2, 32'd3, 32'd4};
    send(s0, d0, 2'b01, 4'hF, 2'b11, "R4 R7 ext128 lower inexact");
    // R5 faults: bad field in extended modes, reserved mode
    send(s0, d0, 2'b01, 4'hE, 2'b00, "R5 fault ext128");
    send(s0, {8{32'h0123_4567}}, 2'b10, 4'h7, 2'b10, "R5 fault ext256");
    send(s0, d0, 2'b11, 4'hF, 2'b00, "R5 fault reserved mode");
    idle(2);
    // R8 gap then back-to-back pseudo-random traffic across modes
    for (int k = 0; k < 60; k++) begin
      logic [VW-1:0] rs, rd;
      for (int j = 0; j < LANES; j++) begin
        rs[j*32 +: 32] = nxt() >> (k % 32);
        rd[j*32 +: 32] = nxt();
      end
      send(rs, rd, 2'(k % 4), (k % 7 == 0) ? 4'h3 : 4'hF, 2'(k / 4), "R1 R2 R6 R8 random");
      if (k % 9 == 0) idle(1);
    end
    idle(3);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 outstanding actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule